// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This unit watches the running calendar time of a real-time clock and raises an alarm when the time reaches a programmed alarm. Software programs five alarm fields in BCD (second, minute, hour, day of month, month) and a five-bit repeat code. The repeat code picks how many of those fields must agree. The options run from a full month-to-second match, which fires once a year, down to no field at all, which fires on every second. The comparison is evaluated only on the one-second tick. A matching second therefore sets the alarm flag once, not on every clock cycle.

On a match the alarm flag is set. If the interrupt enable is set, an active-low interrupt line is also driven. In battery-backup mode a second enable must be set as well. Reading the flag register releases the interrupt at once. The flag itself clears only after that read, so the read returns 1 and a later read returns 0. While the register pointer rests on the flag register address, a fresh interrupt is held back. It is driven one cycle after the pointer moves away. Both enables come out of reset cleared, so an alarm right after power-up only sets the flag.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, irq_n is 1 and alarm_flag is 0. All five alarm fields are 00h, the repeat code is 00000, and both enables (interrupt and battery) are 0, so a matching tick sets only the flag.
- R2: A write with wr_en=1 loads the register selected by wr_sel: 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 control. The control byte holds the repeat code in bits [4:0] (bit 4 = RPT5 ... bit 0 = RPT1), the battery enable in bit 6 and the interrupt enable in bit 7. Bit 5 must be written as 0.
- R3: The comparison uses the low 7 bits of second and minute, the low 6 bits of hour and date, and the low 5 bits of month. Higher bits of both the time and the alarm are ignored.
- R4: The defined repeat codes select these fields. 00000 compares month, date, hour, minute and second. 10000 compares date, hour, minute and second. 11000 compares hour, minute and second. 11100 compares minute and second. 11110 compares second only. 11111 compares nothing.
- R5: Every repeat code outside the defined set behaves as 11111, so the alarm fires on every tick.
- R6: A tick sampled at a clock edge while the selected fields match sets alarm_flag after that edge. Without a tick, alarm_flag stays 0 however long the time matches. The flag holds until a flag read.
- R7: If the interrupt enable is 1, supply mode is normal and reg_ptr differs from the flag address, irq_n goes low after the same edge that sets the flag.
- R8: A flag read (flag_rd=1 at an edge) drives irq_n high after that edge. alarm_flag is still 1 during that read and is 0 after it. If a match tick falls in the same cycle as the read, the new alarm wins: the flag and the interrupt end up set.
- R9: While reg_ptr equals FLAG_ADDR, a new alarm does not drive irq_n low. irq_n goes low after the first edge at which reg_ptr differs from FLAG_ADDR.
- R10: With on_battery=1, an alarm drives irq_n low only if both the battery enable and the interrupt enable are 1. Otherwise it only sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| wr_en | input | 1 | Alarm register write strobe |
| wr_sel | input | 3 | Register select for a write |
| wr_data | input | 8 | Write data |
| flag_rd | input | 1 | Flag register read strobe |
| reg_ptr | input | PTR_W | Current register pointer value |
| on_battery | input | 1 | Battery-backup mode indicator |
| irq_n | output | 1 | Active-low alarm interrupt |
| alarm_flag | output | 1 | Alarm flag value seen by a flag read |

## Verification
The bench builds the unit with a 5-bit pointer and a flag address of 15, so the pointer can be parked on the flag address and then moved off it. This exercises the deferred-interrupt path. Random alarm settings are drawn for all six defined repeat codes and for undefined codes. Each setting is paired with either an exact time match or a time that differs in a single field. This shows that each code ignores exactly the fields it should. Directed cases cover the tick-only evaluation, the read that clears the interrupt before the flag, a read and a tick in the same cycle, the width masking of the upper BCD bits, and the battery-mode enables.

// File: rtl/alarm_pkg.sv
// Shared constants and types for the alarm comparator.
// Field index order is also the write-select encoding of the field registers.
package alarm_pkg;
    localparam int NUM_FIELDS = 5;
    localparam int BYTE_W     = 8;
    localparam int RPT_W      = 5;

    typedef enum logic [2:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DATE  = 3'd3,
        SEL_MONTH = 3'd4,
        SEL_CTRL  = 3'd5
    } wsel_e;

    // Control byte bit positions
    localparam int CTRL_ABE_BIT = 6;
    localparam int CTRL_AFE_BIT = 7;
    localparam int CTRL_RSV_BIT = 5;

    // Defined repeat codes (bit 4 = RPT5)
    localparam logic [RPT_W-1:0] RPT_YEARLY  = 5'b00000;
    localparam logic [RPT_W-1:0] RPT_MONTHLY = 5'b10000;
    localparam logic [RPT_W-1:0] RPT_DAILY   = 5'b11000;
    localparam logic [RPT_W-1:0] RPT_HOURLY  = 5'b11100;
    localparam logic [RPT_W-1:0] RPT_MINUTE  = 5'b11110;
    localparam logic [RPT_W-1:0] RPT_SECOND  = 5'b11111;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] fields_t;
    typedef logic [NUM_FIELDS-1:0]             fmask_t;

    // Significant BCD bits per field (second, minute, hour, date, month)
    function automatic int field_width(input int idx);
        case (idx)
            0, 1:    return 7;
            2, 3:    return 6;
            default: return 5;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] width_mask(input int idx);
        return BYTE_W'((1 << field_width(idx)) - 1);
    endfunction
endpackage

// File: rtl/alarm_reg_bank.sv
// Alarm setting registers: five BCD fields, repeat code and the two enables.
// Assumes one write per cycle; unused select codes are ignored.
module alarm_reg_bank
    import alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    output fields_t             alm_fields,
    output logic [RPT_W-1:0]    rpt_code,
    output logic                afe,
    output logic                abe
);
    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            // Hold one alarm field, loaded when its select is written
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alm_fields[i] <= '0;
                else if (wr_en && (wr_sel == 3'(i)))
                    alm_fields[i] <= wr_data;
            end
        end
    endgenerate

    // Hold the repeat code and the enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_code <= RPT_YEARLY;
            afe      <= 1'b0;
            abe      <= 1'b0;
        end else if (wr_en && (wr_sel == SEL_CTRL)) begin
            rpt_code <= wr_data[RPT_W-1:0];
            abe      <= wr_data[CTRL_ABE_BIT];
            afe      <= wr_data[CTRL_AFE_BIT];
        end
    end

    AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_CTRL)) |-> !wr_data[CTRL_RSV_BIT]); // R2

    AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_CTRL)) |=> (afe == $past(wr_data[CTRL_AFE_BIT]))); // R2
endmodule

// File: rtl/alarm_match_cmp.sv
// Combinational comparator: decodes the repeat code into a field mask and
// compares the width-masked BCD fields. Undefined codes compare nothing.
module alarm_match_cmp
    import alarm_pkg::*;
(
    input  fields_t          now_fields,
    input  fields_t          alm_fields,
    input  logic [RPT_W-1:0] rpt_code,
    output logic             hit
);
    fmask_t eq;
    fmask_t sel;

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
            localparam logic [BYTE_W-1:0] WM = width_mask(i);
            assign eq[i] = ((now_fields[i] & WM) == (alm_fields[i] & WM));
        end
    endgenerate

    // Decode which fields take part in the match
    always_comb begin
        case (rpt_code)
            RPT_YEARLY:  sel = 5'b11111;
            RPT_MONTHLY: sel = 5'b01111;
            RPT_DAILY:   sel = 5'b00111;
            RPT_HOURLY:  sel = 5'b00011;
            RPT_MINUTE:  sel = 5'b00001;
            default:     sel = 5'b00000;
        endcase
    end

    // Match when every selected field agrees
    always_comb begin
        hit = &(eq | ~sel);
    end
endmodule

// File: rtl/alarm_irq_ctrl.sv
// Alarm flag and interrupt state. The flag is set on a matching tick and
// cleared after a flag read; the interrupt is released by the read itself.
// A new interrupt is held pending while the pointer sits on FLAG_ADDR.
module alarm_irq_ctrl #(
    parameter int              PTR_W     = 6,
    parameter logic [PTR_W-1:0] FLAG_ADDR = PTR_W'(15)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hit,
    input  logic             flag_rd,
    input  logic [PTR_W-1:0] ptr,
    input  logic             backup,
    input  logic             afe,
    input  logic             abe,
    output logic             irq_n,
    output logic             flag_q
);
    logic event_w;
    logic arm_w;
    logic at_flag;
    logic active_q;
    logic pending_q;

    assign event_w = tick && hit;
    assign arm_w   = event_w && afe && (!backup || abe);
    assign at_flag = (ptr == FLAG_ADDR);
    assign irq_n   = !active_q;

    // Alarm flag: a new match wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (event_w)
            flag_q <= 1'b1;
        else if (flag_rd)
            flag_q <= 1'b0;
    end

    // Interrupt drive and deferral while the pointer rests on the flag address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            if (flag_rd) begin
                active_q  <= 1'b0;
                pending_q <= 1'b0;
            end else if (pending_q && !at_flag) begin
                active_q  <= 1'b1;
                pending_q <= 1'b0;
            end
            if (arm_w) begin
                if (at_flag)
                    pending_q <= 1'b1;
                else
                    active_q  <= 1'b1;
            end
        end
    end

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> flag_q); // R7

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick)); // R6

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_rd) |=> flag_q); // R6

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !event_w) |=> (irq_n && !flag_q)); // R8

    AST_DEFER_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(ptr) != FLAG_ADDR)); // R9

    AST_BACKUP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && !$past(pending_q)) |->
            ($past(afe) && (!$past(backup) || $past(abe)))); // R10
endmodule

// File: rtl/alarm_match_unit.sv
// Top of the alarm unit: register bank, comparator and interrupt control.
// Assumes the time inputs are stable around the one-second tick.
module alarm_match_unit
    import alarm_pkg::*;
#(
    parameter int               PTR_W     = 6,
    parameter logic [PTR_W-1:0] FLAG_ADDR = PTR_W'(15)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [BYTE_W-1:0]  now_sec,
    input  logic [BYTE_W-1:0]  now_min,
    input  logic [BYTE_W-1:0]  now_hour,
    input  logic [BYTE_W-1:0]  now_date,
    input  logic [BYTE_W-1:0]  now_month,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic               flag_rd,
    input  logic [PTR_W-1:0]   reg_ptr,
    input  logic               on_battery,
    output logic               irq_n,
    output logic               alarm_flag
);
    fields_t          now_fields;
    fields_t          alm_fields;
    logic [RPT_W-1:0] rpt_code;
    logic             afe;
    logic             abe;
    logic             hit;

    assign now_fields = {now_month, now_date, now_hour, now_min, now_sec};

    alarm_reg_bank u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .alm_fields (alm_fields),
        .rpt_code   (rpt_code),
        .afe        (afe),
        .abe        (abe)
    );

    alarm_match_cmp u_cmp (
        .now_fields (now_fields),
        .alm_fields (alm_fields),
        .rpt_code   (rpt_code),
        .hit        (hit)
    );

    alarm_irq_ctrl #(
        .PTR_W     (PTR_W),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .hit     (hit),
        .flag_rd (flag_rd),
        .ptr     (reg_ptr),
        .backup  (on_battery),
        .afe     (afe),
        .abe     (abe),
        .irq_n   (irq_n),
        .flag_q  (alarm_flag)
    );

    AST_SECOND_CODE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (rpt_code == RPT_SECOND)) |=> alarm_flag); // R4
endmodule

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
    localparam int PTR_W = 5;
    localparam logic [PTR_W-1:0] FLAG_A = 5'd15;

    logic clk = 0;
    logic rst_n = 0;
    logic sec_tick = 0;
    logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0, now_month = 0;
    logic wr_en = 0;
    logic [2:0] wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic flag_rd = 0;
    logic [PTR_W-1:0] reg_ptr = 0;
    logic on_battery = 0;
    logic irq_n;
    logic alarm_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alarm_match_unit #(.PTR_W(PTR_W), .FLAG_ADDR(FLAG_A)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_date(now_date), .now_month(now_month),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_rd(flag_rd), .reg_ptr(reg_ptr), .on_battery(on_battery),
        .irq_n(irq_n), .alarm_flag(alarm_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic set_alarm(input logic [7:0] f [5], input logic [4:0] code,
                             input bit afe, input bit abe);
        for (int i = 0; i < 5; i++) wr(3'(i), f[i]);
        wr(3'd5, {afe, abe, 1'b0, code});
    endtask

    task automatic set_now(input logic [7:0] f [5]);
        now_sec = f[0]; now_min = f[1]; now_hour = f[2]; now_date = f[3]; now_month = f[4];
    endtask

    task automatic tick();
        sec_tick = 1; step(); sec_tick = 0;
    endtask

    task automatic read_flag(input string tag, input int exp_val);
        flag_rd = 1;
        chk(tag, int'(alarm_flag), exp_val);
        step();
        flag_rd = 0;
    endtask

    // Field selection per repeat code (index 0 second .. 4 month)
    function automatic logic [4:0] sel_of(input logic [4:0] code);
        case (code)
            5'b00000: return 5'b11111;
            5'b10000: return 5'b01111;
            5'b11000: return 5'b00111;
            5'b11100: return 5'b00011;
            5'b11110: return 5'b00001;
            default:  return 5'b00000;
        endcase
    endfunction

    function automatic bit exp_hit(input logic [4:0] code, input logic [7:0] a [5],
                                   input logic [7:0] n [5]);
        int w [5] = '{7, 7, 6, 6, 5};
        logic [4:0] s = sel_of(code);
        bit r = 1;
        for (int i = 0; i < 5; i++) begin
            logic [7:0] m = 8'((1 << w[i]) - 1);
            if (s[i] && ((a[i] & m) != (n[i] & m))) r = 0;
        end
        return r;
    endfunction

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] al [5];
        logic [7:0] nw [5];
        logic [4:0] codes [6] = '{5'b00000, 5'b10000, 5'b11000, 5'b11100, 5'b11110, 5'b11111};
        void'($urandom(32'd1234));

        repeat (3) step();
        rst_n = 1;
        step();
        chk("R1 irq_n after reset", int'(irq_n), 1);
        chk("R1 flag after reset", int'(alarm_flag), 0);
        // Reset alarm is all-zero fields with code 00000 and enables off
        tick();
        chk("R1 zero alarm matches zero time", int'(alarm_flag), 1);
        chk("R1 enables cleared, no irq", int'(irq_n), 1);
        read_flag("R8 read returns set flag", 1);
        chk("R8 flag clear after read", int'(alarm_flag), 0);

        // R5 undefined code fires on any tick
        al = '{bcd(10), bcd(20), bcd(5), bcd(12), bcd(3)};
        nw = '{bcd(11), bcd(21), bcd(6), bcd(13), bcd(4)};
        set_alarm(al, 5'b01010, 1, 0);
        set_now(nw);
        tick();
        chk("R5 undefined code sets flag", int'(alarm_flag), 1);
        chk("R7 irq low after tick", int'(irq_n), 0);
        // R8 read clears irq before flag
        read_flag("R8 flag still 1 during read", 1);
        chk("R8 irq released by read", int'(irq_n), 1);
        read_flag("R8 second read sees 0", 0);

        // R6 no tick, no flag
        set_alarm(al, 5'b00000, 1, 0);
        set_now(al);
        repeat (3) step();
        chk("R6 match without tick", int'(alarm_flag), 0);
        tick();
        chk("R6 tick sets flag", int'(alarm_flag), 1);
        step();
        chk("R6 flag holds", int'(alarm_flag), 1);
        read_flag("R8 clear", 1);

        // R3 upper bits ignored
        nw = al;
        nw[2] = al[2] | 8'hC0;
        nw[4] = al[4] | 8'hE0;
        set_now(nw);
        tick();
        chk("R3 upper bits ignored", int'(alarm_flag), 1);
        read_flag("R8 clear", 1);

        // R9 deferral on flag address
        set_now(al);
        reg_ptr = FLAG_A;
        tick();
        chk("R9 flag set while deferred", int'(alarm_flag), 1);
        chk("R9 irq held off", int'(irq_n), 1);
        repeat (3) step();
        chk("R9 irq still held", int'(irq_n), 1);
        reg_ptr = 5'd3;
        step();
        chk("R9 irq after pointer moves", int'(irq_n), 0);
        read_flag("R8 clear", 1);

        // R8 read and match tick in same cycle
        tick();
        chk("R7 irq set", int'(irq_n), 0);
        flag_rd = 1; sec_tick = 1;
        step();
        flag_rd = 0; sec_tick = 0;
        chk("R8 tick beats read flag", int'(alarm_flag), 1);
        chk("R8 tick beats read irq", int'(irq_n), 0);
        read_flag("R8 clear", 1);

        // R10 battery mode
        on_battery = 1;
        set_alarm(al, 5'b00000, 1, 0);
        tick();
        chk("R10 flag set on battery", int'(alarm_flag), 1);
        chk("R10 no irq without battery enable", int'(irq_n), 1);
        read_flag("R8 clear", 1);
        set_alarm(al, 5'b00000, 1, 1);
        tick();
        chk("R10 irq with both enables", int'(irq_n), 0);
        read_flag("R8 clear", 1);
        set_alarm(al, 5'b00000, 0, 1);
        tick();
        chk("R10 no irq without interrupt enable", int'(irq_n), 1);
        read_flag("R8 clear", 1);
        on_battery = 0;

        // R4 random: defined and undefined codes, exact or single-field miss
        for (int it = 0; it < 80; it++) begin
            logic [4:0] code;
            bit e;
            int f;
            if ($urandom_range(0, 3) == 0) code = 5'($urandom);
            else code = codes[$urandom_range(0, 5)];
            al = '{bcd($urandom_range(0, 59)), bcd($urandom_range(0, 59)),
                   bcd($urandom_range(0, 23)), bcd($urandom_range(1, 31)),
                   bcd($urandom_range(1, 12))};
            nw = al;
            if ($urandom_range(0, 2) != 0) begin
                f = $urandom_range(0, 4);
                nw[f] = al[f] ^ 8'h01;
            end
            set_alarm(al, code, 1, 0);
            set_now(nw);
            e = exp_hit(code, al, nw);
            tick();
            chk($sformatf("R4 code %b flag", code), int'(alarm_flag), int'(e));
            chk($sformatf("R7 code %b irq", code), int'(irq_n), int'(!e));
            flag_rd = 1; step(); flag_rd = 0;
            chk("R8 random clear", int'(alarm_flag), 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule